// File: doc/BRIEF.md
# Serial-Bus Eight-Bit Port Expander

This block is a two-wire serial bus slave (I2C) that owns one eight-bit general-purpose port. The bus clock and data lines are oversampled by the system clock. Each line passes through a two-flop synchronizer and a glitch filter whose length is a parameter. The slave answers to a seven-bit address made of a fixed four-bit prefix and three strap inputs. It acknowledges by pulling the data line low through an open-drain style enable.

A write transfer sends every acknowledged data byte straight to the port output latches, with no register map in between. Bits written to 1 also raise a per-bit strong pull-up enable, which lasts until the next bus clock falling edge. A read transfer captures the port pins at the end of each acknowledge and shifts them out most significant bit first. The master ends a read by withholding its acknowledge, and the slave then releases the data line.

Top module: `pxp_top`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits are {prefix, strap[2:0]}. The prefix is 4'b0100 by default and 4'b0111 when ALT_PREFIX is 1. Bit 0 is the direction (0 = write, 1 = read). The acknowledge holds the data line low for the whole ninth clock. Every received data byte is acknowledged the same way.
- R2: After an address that does not match, the slave drives nothing and leaves the latches unchanged until the next START.
- R3: In a write, each data byte is loaded into the eight port latches at the rising bus clock of its acknowledge. Any number of bytes may follow one address.
- R4: In a read, the port pins are captured on the bus clock falling edge that ends the preceding acknowledge and are sent MSB first. Each later byte is a fresh capture.
- R5: When the master does not acknowledge a read byte, the slave releases the data line and drives nothing until the next START.
- R6: A START (data falling while clock high) or a STOP (data rising while clock high) is honoured at any point. It abandons a partial byte without touching the latches. A START restarts address reception.
- R7: During and after reset the latches read 8'hFF, the data line is released and every pull-up enable is 0.
- R8: A latch bit loaded with 1 has its pull-up enable set from the load until the next bus clock falling edge. A pull-up enable is never set on a latch bit that holds 0.
- R9: A pulse on either bus line that lasts fewer than FILT_LEN system clocks (25 at the default of 26, i.e. 100 ns at 250 MHz) has no effect.
- R10: The slave changes its data line drive only while the filtered bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-on reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaDriveLow | output | 1 | When 1, the open-drain data driver pulls the line low |
| strapAddr | input | 3 | Low three address bits from board straps |
| portPins | input | 8 | Port pin levels sampled for reads |
| portLatch | output | 8 | Port output latch values |
| portBoost | output | 8 | Per-bit strong pull-up enable |

## Verification
The bench aims at multi-byte writes and reads. A slave that counted bytes wrongly would load a stale or shifted value, or read back pins captured at the wrong moment. It sends a STOP in the middle of a byte and a repeated START. A design that did not abort would commit half a byte or treat the second address as data. It sends foreign addresses, including the alternate prefix, which a loose comparator would acknowledge. It injects pulses just under the filter length on both lines. An unfiltered design would see an extra clock edge or a false START and corrupt the byte.

// File: rtl/pxp_pkg.sv
package pxp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_AACK, PH_WDAT, PH_WACK, PH_RDAT, PH_RACK
  } pxp_phase_t;

  typedef struct packed {
    logic bitIn;     // filtered data line level
    logic shiftIn;   // shift bitIn into the byte register
    logic shiftOut;  // advance the outgoing byte
    logic capture;   // load port pins into the byte register
    logic commit;    // move the byte register to the latches
    logic clrBoost;  // bus clock fell: end pull-up pulses
  } pxp_strobe_t;
endpackage

// File: rtl/pxp_glitch_filter.sv
module pxp_glitch_filter #(
  parameter int FILT_LEN = 26
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic lvlOut
);
  localparam int CW = $clog2(FILT_LEN + 1);
  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;
  logic          lvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      runCnt <= '0;
      lvl    <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == lvl) begin
        runCnt <= '0;
      end else if (runCnt == CW'(FILT_LEN - 1)) begin
        lvl    <= syncQ[1];
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  assign lvlOut = lvl;

  // R9: the level only moves after a full run of differing samples
  a_r9_full_run: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lvl) |-> $past(runCnt) == CW'(FILT_LEN - 1));
endmodule

// File: rtl/pxp_ctrl.sv
module pxp_ctrl
  import pxp_pkg::*;
#(
  parameter int  DATA_W     = 8,
  parameter bit  ALT_PREFIX = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic [2:0]        strapAddr,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txBit,
  output pxp_strobe_t       strb,
  output logic              sdaDriveLow
);
  localparam int          BW     = $clog2(DATA_W + 1);
  localparam logic [3:0]  PREFIX = ALT_PREFIX ? 4'b0111 : 4'b0100;

  pxp_phase_t    phase;
  logic [BW-1:0] bitCnt;
  logic          sclQ, sdaQ, rwQ, mAckQ;
  logic          sclRise, sclFall, startEv, stopEv, addrHit, byteDone;

  assign sclRise  = sclF & ~sclQ;
  assign sclFall  = ~sclF & sclQ;
  assign startEv  = sclF & sclQ & sdaQ & ~sdaF;
  assign stopEv   = sclF & sclQ & ~sdaQ & sdaF;
  assign addrHit  = rxByte[7:1] == {PREFIX, strapAddr};
  assign byteDone = bitCnt == BW'(DATA_W);

  always_comb begin
    strb          = '0;
    strb.bitIn    = sdaF;
    strb.clrBoost = sclFall;
    if (!startEv && !stopEv) begin
      unique case (phase)
        PH_ADDR, PH_WDAT: strb.shiftIn  = sclRise & ~byteDone;
        PH_AACK:          strb.capture  = sclFall & rwQ;
        PH_WACK:          strb.commit   = sclRise;
        PH_RDAT:          strb.shiftOut = sclFall & ~byteDone;
        PH_RACK:          strb.capture  = sclFall & mAckQ;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      sclQ   <= 1'b1;
      sdaQ   <= 1'b1;
      rwQ    <= 1'b0;
      mAckQ  <= 1'b0;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
      if (startEv) begin
        phase  <= PH_ADDR;
        bitCnt <= '0;
      end else if (stopEv) begin
        phase <= PH_IDLE;
      end else begin
        unique case (phase)
          PH_ADDR, PH_WDAT, PH_RDAT: begin
            if (sclRise) bitCnt <= bitCnt + 1'b1;
            if (sclFall && byteDone) begin
              if (phase == PH_WDAT)      phase <= PH_WACK;
              else if (phase == PH_RDAT) phase <= PH_RACK;
              else if (addrHit) begin
                phase <= PH_AACK;
                rwQ   <= rxByte[0];
              end else phase <= PH_IDLE;
            end
          end
          PH_AACK: if (sclFall) begin
            bitCnt <= '0;
            phase  <= rwQ ? PH_RDAT : PH_WDAT;
          end
          PH_WACK: if (sclFall) begin
            bitCnt <= '0;
            phase  <= PH_WDAT;
          end
          PH_RACK: begin
            if (sclRise) mAckQ <= ~sdaF;
            if (sclFall) begin
              bitCnt <= '0;
              phase  <= mAckQ ? PH_RDAT : PH_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaDriveLow = (phase == PH_AACK) | (phase == PH_WACK) |
                       ((phase == PH_RDAT) & ~txBit);

  // R6: a STOP always returns the slave to idle
  a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> phase == PH_IDLE);
  // R2: a foreign address ends in idle
  a_r2_miss_idle: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ADDR && sclFall && byteDone && !addrHit && !startEv && !stopEv)
      |=> phase == PH_IDLE);
  // R5: a missing master acknowledge ends the read
  a_r5_nack_idle: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RACK && sclFall && !mAckQ && !startEv && !stopEv)
      |=> phase == PH_IDLE && !sdaDriveLow);
endmodule

// File: rtl/pxp_dpath.sv
module pxp_dpath
  import pxp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pxp_strobe_t       strb,
  input  logic [DATA_W-1:0] portPins,
  output logic [DATA_W-1:0] rxByte,
  output logic              txBit,
  output logic [DATA_W-1:0] portLatch,
  output logic [DATA_W-1:0] portBoost
);
  logic [DATA_W-1:0] byteReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteReg   <= '1;
      portLatch <= '1;
      portBoost <= '0;
    end else begin
      if (strb.capture)       byteReg <= portPins;
      else if (strb.shiftIn)  byteReg <= {byteReg[DATA_W-2:0], strb.bitIn};
      else if (strb.shiftOut) byteReg <= {byteReg[DATA_W-2:0], 1'b1};
      if (strb.commit) begin
        portLatch <= byteReg;
        portBoost <= byteReg;
      end else if (strb.clrBoost) begin
        portBoost <= '0;
      end
    end
  end

  assign rxByte = byteReg;
  assign txBit  = byteReg[DATA_W-1];

  // R3: latches move only on a commit strobe
  a_r3_latch_commit: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portLatch) |-> $past(strb.commit));
  // R8: a pull-up enable only sits on a latch bit that holds 1
  a_r8_boost_subset: assert property (@(posedge clk) disable iff (!rstN)
    (portBoost & ~portLatch) == '0);
  // R8: a bus clock falling edge ends every pulse
  a_r8_boost_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrBoost && !strb.commit) |=> portBoost == '0);
endmodule

// File: rtl/pxp_top.sv
module pxp_top
  import pxp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FILT_LEN   = 26,
  parameter bit ALT_PREFIX = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic [2:0]        strapAddr,
  input  logic [DATA_W-1:0] portPins,
  output logic [DATA_W-1:0] portLatch,
  output logic [DATA_W-1:0] portBoost
);
  logic [1:0]        rawLines, fltLines;
  logic [DATA_W-1:0] rxByte;
  logic              txBit, sclF, sdaF;
  pxp_strobe_t       strb;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : g_line
    pxp_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[g]), .lvlOut(fltLines[g]));
  end

  assign sclF = fltLines[0];
  assign sdaF = fltLines[1];

  pxp_ctrl #(.DATA_W(DATA_W), .ALT_PREFIX(ALT_PREFIX)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF), .strapAddr(strapAddr),
    .rxByte(rxByte), .txBit(txBit), .strb(strb), .sdaDriveLow(sdaDriveLow));

  pxp_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .portPins(portPins),
    .rxByte(rxByte), .txBit(txBit), .portLatch(portLatch), .portBoost(portBoost));

  // R10: the data drive only moves while the filtered clock is low
  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclF);
endmodule

// File: tb/sim_pxp_top.sv
module sim_pxp_top;
  localparam int Q = 60;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] AW = {4'b0100, STRAP, 1'b0};
  localparam logic [7:0] AR = {4'b0100, STRAP, 1'b1};

  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [7:0] pins = 8'h00;
  logic sdaDriveLow;
  logic [7:0] portLatch, portBoost;
  wire sdaLine = sdaM & ~sdaDriveLow;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] expQ[$];
  logic [7:0] prevLatch = 8'hFF;

  always #2 clk = ~clk;

  pxp_top u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .strapAddr(STRAP), .portPins(pins),
    .portLatch(portLatch), .portBoost(portBoost));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: every latch change pops one expected byte
  always @(negedge clk) begin
    if (rstN && portLatch != prevLatch) begin
      if (expQ.size() == 0) check(1'b0, "R3", portLatch, prevLatch);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(portLatch == e, "R3", portLatch, e);
      end
      prevLatch = portLatch;
    end
  end

  task automatic sendStart();
    sdaM = 1'b1; waitc(Q); sclM = 1'b1; waitc(Q);
    sdaM = 1'b0; waitc(Q); sclM = 1'b0; waitc(Q);
  endtask

  task automatic sendStop();
    sdaM = 1'b0; waitc(Q); sclM = 1'b1; waitc(Q); sdaM = 1'b1; waitc(Q);
  endtask

  task automatic clockBit(input logic b, input bit glitch, output logic seen);
    sdaM = b;
    if (glitch) begin
      waitc(10); sclM = 1'b1; waitc(20); sclM = 1'b0; waitc(Q - 30);
    end else waitc(Q);
    sclM = 1'b1; waitc(Q / 2);
    if (glitch && b) begin
      sdaM = 1'b0; waitc(20); sdaM = 1'b1; waitc(Q / 2 - 20);
    end else waitc(Q / 2);
    seen = sdaLine;
    waitc(Q); sclM = 1'b0; waitc(Q);
  endtask

  task automatic writeByte(input logic [7:0] d, input bit glitch, input bit boostChk,
                           output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(d[i], glitch && (i == 3 || i == 0), s);
    sdaM = 1'b1; waitc(Q); sclM = 1'b1; waitc(Q);
    ack = ~sdaLine;
    if (boostChk) check(portBoost == d, "R8", portBoost, d);
    waitc(Q); sclM = 1'b0; waitc(Q);
    if (boostChk) check(portBoost == 8'h00, "R8", portBoost, 0);
  endtask

  task automatic readByte(input bit mAck, input logic [7:0] nextPins, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic early, late;
      sdaM = 1'b1; waitc(Q); sclM = 1'b1; waitc(Q / 4);
      early = sdaLine; waitc(Q - Q / 4);
      d[i] = sdaLine; waitc(Q - 2);
      late = sdaLine; waitc(2);
      check(early == late, "R10", late, early);
      sclM = 1'b0; waitc(Q);
    end
    pins = nextPins;
    sdaM = ~mAck; waitc(Q); sclM = 1'b1; waitc(2 * Q); sclM = 1'b0; waitc(Q);
  endtask

  initial begin
    logic ack, s;
    logic [7:0] rd;
    waitc(5);
    check(portLatch == 8'hFF, "R7", portLatch, 8'hFF);
    check(sdaDriveLow == 1'b0, "R7", sdaDriveLow, 0);
    check(portBoost == 8'h00, "R7", portBoost, 0);
    rstN = 1'b1; waitc(10);
    check(portLatch == 8'hFF, "R7", portLatch, 8'hFF);

    // Multi-byte write with boost pulses
    sendStart();
    writeByte(AW, 0, 0, ack); check(ack, "R1", ack, 1);
    expQ.push_back(8'h3C); writeByte(8'h3C, 0, 1, ack); check(ack, "R1", ack, 1);
    expQ.push_back(8'hA5); writeByte(8'hA5, 0, 1, ack); check(ack, "R3", ack, 1);
    sendStop();

    // Foreign address
    sendStart();
    writeByte({4'b0100, 3'b000, 1'b0}, 0, 0, ack); check(!ack, "R2", ack, 0);
    writeByte(8'h00, 0, 0, ack); check(!ack, "R2", ack, 0);
    sendStop();
    check(portLatch == 8'hA5, "R2", portLatch, 8'hA5);
    sendStart();
    writeByte({4'b0111, STRAP, 1'b0}, 0, 0, ack); check(!ack, "R1", ack, 0);
    sendStop();

    // Read: two captures, then master NACK
    pins = 8'h96;
    sendStart();
    writeByte(AR, 0, 0, ack); check(ack, "R1", ack, 1);
    readByte(1'b1, 8'h5A, rd); check(rd == 8'h96, "R4", rd, 8'h96);
    readByte(1'b0, 8'h00, rd); check(rd == 8'h5A, "R4", rd, 8'h5A);
    clockBit(1'b1, 0, s); check(s == 1'b1, "R5", s, 1);
    check(sdaDriveLow == 1'b0, "R5", sdaDriveLow, 0);
    sendStop();

    // STOP in mid byte, then repeated START
    sendStart();
    writeByte(AW, 0, 0, ack);
    for (int i = 0; i < 4; i++) clockBit(1'b0, 0, s);
    sendStop();
    check(portLatch == 8'hA5, "R6", portLatch, 8'hA5);
    sendStart();
    writeByte(AW, 0, 0, ack);
    expQ.push_back(8'h0F); writeByte(8'h0F, 0, 1, ack);
    sendStart();
    writeByte(AW, 0, 0, ack); check(ack, "R6", ack, 1);
    expQ.push_back(8'hF0); writeByte(8'hF0, 0, 1, ack);
    sendStop();
    check(portLatch == 8'hF0, "R6", portLatch, 8'hF0);

    // Short pulses on both lines
    sendStart();
    writeByte(AW, 0, 0, ack);
    expQ.push_back(8'h89); writeByte(8'h89, 1, 0, ack); check(ack, "R9", ack, 1);
    sendStop();
    check(portLatch == 8'h89, "R9", portLatch, 8'h89);

    waitc(10);
    check(expQ.size() == 0, "R3", expQ.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule